// File: doc/BRIEF.md
# Wear-Aware Frequency/Voltage Level Governor

This block picks the operating point of a processor core as one combined frequency/voltage level index. The index ranges from zero, the slowest and lowest voltage, up to a configurable top level. A prescaler divides the core clock into a decision interval set by software. In a typical deployment the interval is between one and ten milliseconds. At each decision point the block samples three sensor readings (accumulated wear stress, die temperature and power draw) and a two-bit performance-demand code from the workload manager.

For each sensor the block checks two things: whether the reading is above its ceiling, and whether it has risen too fast since the previous decision point. If any reading or any rise is critical, the index steps down by one. This happens before timing margins are used up. It is not a reaction to timing that has already degraded. If nothing is critical, the demand code decides the step: one level down when the workload would still be served at a lower level, no change, or one level up when more speed is needed. Each change to the index comes with a one-cycle strobe, so the clock generator and the supply regulator can act on it.

Top module: `wear_governor`

## Requirements
- R1: While `rst_ni` is low, `level_o` equals the parameter `INIT_LEVEL` (default 7) and `level_chg_o` is 0.
- R2: A decision is taken once every `cfg_interval_i`+1 clock cycles. The first decision uses the inputs present in the `cfg_interval_i`+1-th cycle after reset release. The result appears on the outputs one cycle later. Between decisions `level_o` holds its value and `level_chg_o` stays 0.
- R3: A sensor reading is critical when it is strictly greater than its ceiling in `crit_lim_i`. A reading equal to its ceiling is not critical. Sensor lanes are ordered as 0 = wear stress, 1 = temperature, 2 = power.
- R4: A trend is critical when the reading exceeds the same lane's reading at the previous decision point by strictly more than `slope_lim_i`. A fall, or a rise equal to the limit, is not critical. At the first decision after reset no trend is critical.
- R5: When any reading or trend is critical, the level drops by one whatever the demand code says, including a request to go up.
- R6: With nothing critical and demand code 0 (lower level suffices), the level drops by one.
- R7: With nothing critical and demand code 1 or 3 (keep), the level is unchanged.
- R8: With nothing critical and demand code 2 (more speed needed), the level rises by one.
- R9: The level never goes below 0 or above `MAX_LEVEL`. A step that would leave this range leaves the level unchanged.
- R10: `level_chg_o` is high for exactly one cycle, in the cycle in which `level_o` first shows a new value, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_interval_i | input | IVL_W | Decision interval in clock cycles, minus one |
| sens_i | input | NUM_SENS x SENS_W | Sensor readings: lane 0 wear stress, lane 1 temperature, lane 2 power |
| crit_lim_i | input | NUM_SENS x SENS_W | Per-lane ceiling for the reading |
| slope_lim_i | input | NUM_SENS x SENS_W | Per-lane limit on the rise between decisions |
| demand_i | input | 2 | 0 lower ok, 1 keep, 2 raise, 3 keep |
| level_o | output | LVL_W | Current frequency/voltage level index |
| level_chg_o | output | 1 | One-cycle pulse when the level changes |

## Verification
The stimulus holds steady readings while the bench sweeps all four demand codes. This separates the down, hold and up paths and the two codes that both mean keep. Separate patterns push each lane on its own just over its ceiling, exactly onto its ceiling, with a fast rise, with a rise equal to the slope limit, and with a fall. This shows apart value checks, trend checks and the strict-versus-inclusive comparisons. Critical readings are paired with a request to go up, which shows that criticality wins. Long runs of down requests and raise requests drive the index against both rails. A single-cycle check between decisions confirms that no strobe or level change leaks outside the decision points.

// File: rtl/wear_gov_pkg.sv
package wear_gov_pkg;

    localparam int NUM_SENS = 3;

    localparam int LANE_STRESS = 0;
    localparam int LANE_TEMP   = 1;
    localparam int LANE_POWER  = 2;

    typedef enum logic [1:0] {
        DEM_LOWER = 2'd0,
        DEM_KEEP  = 2'd1,
        DEM_RAISE = 2'd2,
        DEM_KEEP2 = 2'd3
    } demand_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } step_e;

endpackage

// File: rtl/wear_gov_tick.sv
module wear_gov_tick #(
    parameter int IVL_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IVL_W-1:0] cfg_interval_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [IVL_W-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic        at_end;

    always_comb begin
        st_d   = st_q;
        // Using >= keeps the counter bounded if the interval is shortened mid-count.
        at_end = (st_q.cnt >= cfg_interval_i);
        if (at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = at_end;

endmodule

// File: rtl/wear_gov_chan.sv
module wear_gov_chan #(
    parameter int SENS_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [SENS_W-1:0] sample_i,
    input  logic [SENS_W-1:0] ceil_i,
    input  logic [SENS_W-1:0] slope_i,
    output logic              val_crit_o,
    output logic              trend_crit_o
);

    typedef struct packed {
        logic [SENS_W-1:0] prev;
        logic              seen;
    } chan_state_t;

    chan_state_t       st_d, st_q;
    logic [SENS_W-1:0] rise;
    logic              rising;

    always_comb begin
        st_d   = st_q;
        rising = (sample_i > st_q.prev);
        rise   = rising ? (sample_i - st_q.prev) : '0;

        val_crit_o   = (sample_i > ceil_i);
        trend_crit_o = st_q.seen && rising && (rise > slope_i);

        if (tick_i) begin
            st_d.prev = sample_i;
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wear_gov_decide.sv
module wear_gov_decide
    import wear_gov_pkg::*;
#(
    parameter int MAX_LEVEL  = 7,
    parameter int INIT_LEVEL = 7,
    parameter int LVL_W      = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             crit_i,
    input  logic [1:0]       demand_i,
    output logic [LVL_W-1:0] level_o,
    output logic             chg_o
);

    localparam logic [LVL_W-1:0] TOP  = LVL_W'(MAX_LEVEL);
    localparam logic [LVL_W-1:0] INIT = LVL_W'(INIT_LEVEL);

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             chg;
    } dec_state_t;

    dec_state_t st_d, st_q;
    step_e      step;
    demand_e    dem;

    always_comb begin
        dem  = demand_e'(demand_i);
        step = STEP_NONE;
        if (crit_i) begin
            step = STEP_DOWN;
        end else begin
            unique case (dem)
                DEM_LOWER: step = STEP_DOWN;
                DEM_RAISE: step = STEP_UP;
                default:   step = STEP_NONE;
            endcase
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (tick_i) begin
            unique case (step)
                STEP_DOWN: if (st_q.level != '0) st_d.level = st_q.level - 1'b1;
                STEP_UP:   if (st_q.level < TOP) st_d.level = st_q.level + 1'b1;
                default:   st_d.level = st_q.level;
            endcase
            st_d.chg = (st_d.level != st_q.level);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.level <= INIT;
            st_q.chg   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign chg_o   = st_q.chg;

endmodule

// File: rtl/wear_governor.sv
module wear_governor
    import wear_gov_pkg::*;
#(
    parameter int IVL_W      = 24,
    parameter int SENS_W     = 10,
    parameter int MAX_LEVEL  = 7,
    parameter int INIT_LEVEL = MAX_LEVEL,
    parameter int LVL_W      = $clog2(MAX_LEVEL + 1)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [IVL_W-1:0]                 cfg_interval_i,
    input  logic [NUM_SENS-1:0][SENS_W-1:0]  sens_i,
    input  logic [NUM_SENS-1:0][SENS_W-1:0]  crit_lim_i,
    input  logic [NUM_SENS-1:0][SENS_W-1:0]  slope_lim_i,
    input  logic [1:0]                       demand_i,
    output logic [LVL_W-1:0]                 level_o,
    output logic                             level_chg_o
);

    logic                tick;
    logic [NUM_SENS-1:0] val_crit;
    logic [NUM_SENS-1:0] trend_crit;
    logic                crit_any;

    wear_gov_tick #(
        .IVL_W (IVL_W)
    ) i_tick (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .cfg_interval_i (cfg_interval_i),
        .tick_o         (tick)
    );

    for (genvar g = 0; g < NUM_SENS; g++) begin : g_lane
        wear_gov_chan #(
            .SENS_W (SENS_W)
        ) i_chan (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .tick_i       (tick),
            .sample_i     (sens_i[g]),
            .ceil_i       (crit_lim_i[g]),
            .slope_i      (slope_lim_i[g]),
            .val_crit_o   (val_crit[g]),
            .trend_crit_o (trend_crit[g])
        );
    end

    assign crit_any = (|val_crit) | (|trend_crit);

    wear_gov_decide #(
        .MAX_LEVEL  (MAX_LEVEL),
        .INIT_LEVEL (INIT_LEVEL),
        .LVL_W      (LVL_W)
    ) i_decide (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .crit_i   (crit_any),
        .demand_i (demand_i),
        .level_o  (level_o),
        .chg_o    (level_chg_o)
    );

endmodule

// File: rtl/wear_governor_chk.sv
module wear_governor_chk #(
    parameter int MAX_LEVEL = 7,
    parameter int LVL_W     = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick,
    input logic             crit_any,
    input logic [LVL_W-1:0] level_o,
    input logic             level_chg_o
);

    // R9
    level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(level_o) <= MAX_LEVEL);

    // R9
    single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (level_o == $past(level_o)
                  || int'(level_o) + 1 == int'($past(level_o))
                  || int'(level_o) == int'($past(level_o)) + 1));

    // R10
    strobe_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (level_chg_o == (level_o != $past(level_o))));

    // R2
    strobe_at_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_chg_o |-> $past(tick));

    // R5
    crit_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && crit_any && level_o != '0) |=> (int'(level_o) + 1 == int'($past(level_o))));

endmodule

bind wear_governor wear_governor_chk #(
    .MAX_LEVEL (MAX_LEVEL),
    .LVL_W     (LVL_W)
) i_wear_governor_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick        (tick),
    .crit_any    (crit_any),
    .level_o     (level_o),
    .level_chg_o (level_chg_o)
);

// File: tb/test_wear_governor.sv
module test_wear_governor;

    localparam int IVL_W  = 24;
    localparam int SENS_W = 10;
    localparam int MAXL   = 7;
    localparam int LVL_W  = 3;
    localparam int NS     = 3;
    localparam int IVL    = 7;

    logic                       clk_i = 1'b0;
    logic                       rst_ni = 1'b0;
    logic [IVL_W-1:0]           cfg_interval_i = IVL_W'(IVL);
    logic [NS-1:0][SENS_W-1:0]  sens_i = '0;
    logic [NS-1:0][SENS_W-1:0]  crit_lim_i;
    logic [NS-1:0][SENS_W-1:0]  slope_lim_i;
    logic [1:0]                 demand_i = 2'd1;
    logic [LVL_W-1:0]           level_o;
    logic                       level_chg_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    exp_lvl_q[$];
    bit    exp_chg_q[$];
    string tag_q[$];

    int m_level = MAXL;
    int m_prev[NS];
    bit m_seen = 0;

    always #4 clk_i = ~clk_i;

    wear_governor #(
        .IVL_W      (IVL_W),
        .SENS_W     (SENS_W),
        .MAX_LEVEL  (MAXL),
        .INIT_LEVEL (MAXL)
    ) i_wear_governor (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .cfg_interval_i (cfg_interval_i),
        .sens_i         (sens_i),
        .crit_lim_i     (crit_lim_i),
        .slope_lim_i    (slope_lim_i),
        .demand_i       (demand_i),
        .level_o        (level_o),
        .level_chg_o    (level_chg_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Driver: applies one decision's inputs, predicts the result, waits one interval.
    task automatic decide(input int s0, input int s1, input int s2, input int dem, input string tag);
        int  s[NS];
        bit  crit;
        int  nxt;
        s[0] = s0; s[1] = s1; s[2] = s2;
        crit = 0;
        for (int i = 0; i < NS; i++) begin
            if (s[i] > 800) crit = 1;
            if (m_seen && s[i] > m_prev[i] && (s[i] - m_prev[i]) > 50) crit = 1;
        end
        nxt = m_level;
        if (crit || dem == 0) begin
            if (m_level > 0) nxt = m_level - 1;
        end else if (dem == 2) begin
            if (m_level < MAXL) nxt = m_level + 1;
        end
        exp_lvl_q.push_back(nxt);
        exp_chg_q.push_back(nxt != m_level);
        tag_q.push_back(tag);
        m_level = nxt;
        for (int i = 0; i < NS; i++) m_prev[i] = s[i];
        m_seen = 1;
        for (int i = 0; i < NS; i++) sens_i[i] = SENS_W'(s[i]);
        demand_i = 2'(dem);
        for (int c = 0; c <= IVL; c++) @(posedge clk_i);
        @(negedge clk_i);
    endtask

    // Monitor: quiet checks between decisions, scoreboard compare at each decision.
    initial begin
        int last;
        wait (rst_ni === 1'b1);
        last = MAXL;
        forever begin
            for (int c = 0; c <= IVL; c++) begin
                @(posedge clk_i);
                @(negedge clk_i);
                if (c < IVL) begin
                    check(level_chg_o == 1'b0, "R10 strobe quiet", int'(level_chg_o), 0);
                    check(int'(level_o) == last, "R2 level held", int'(level_o), last);
                end else if (exp_lvl_q.size() > 0) begin
                    int    el;
                    bit    ec;
                    string t;
                    el = exp_lvl_q.pop_front();
                    ec = exp_chg_q.pop_front();
                    t  = tag_q.pop_front();
                    check(int'(level_o) == el, t, int'(level_o), el);
                    check(level_chg_o == ec, {t, " R10 strobe"}, int'(level_chg_o), int'(ec));
                    last = int'(level_o);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            crit_lim_i[i]  = SENS_W'(800);
            slope_lim_i[i] = SENS_W'(50);
        end
        repeat (3) @(negedge clk_i);
        check(int'(level_o) == MAXL, "R1 reset level", int'(level_o), MAXL);
        check(level_chg_o == 1'b0, "R1 reset strobe", int'(level_chg_o), 0);
        rst_ni = 1'b1;

        decide(100, 100, 100, 1, "R4 first decision no trend");
        decide(100, 100, 100, 2, "R9 raise at top");
        decide(100, 100, 100, 0, "R6 lower ok");
        decide(100, 100, 100, 0, "R6 lower ok again");
        decide(100, 100, 100, 2, "R8 raise");
        decide(100, 900, 100, 2, "R3 R5 hot over raise");
        decide(100, 100, 140, 1, "R7 keep, fall and small rise");
        decide(100, 100, 190, 3, "R4 rise equal limit, R7 code 3");
        decide(260, 100, 190, 2, "R4 R5 stress surge over raise");
        decide(260, 100, 190, 2, "R8 raise stable");
        decide(260, 100, 800, 2, "R4 power surge");
        decide(260, 100, 800, 2, "R3 equal ceiling not critical");
        decide(260, 100, 801, 2, "R3 power over ceiling");
        for (int k = 0; k < 8; k++) decide(100, 100, 100, 0, "R6 R9 lower to floor");
        decide(900, 100, 100, 2, "R9 R5 critical at floor");
        decide(100, 100, 100, 2, "R8 raise from floor");
        for (int k = 0; k < 8; k++) decide(100, 100, 100, 2, "R8 R9 raise to top");

        repeat (2) @(negedge clk_i);
        check(exp_lvl_q.size() == 0, "R2 all decisions observed", exp_lvl_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

endmodule